// File: doc/BRIEF.md
# Open-Drain Pin Pair Control Register

This block is one 32-bit control register that software uses to bit-bang a two-wire serial bus on a pair of open-drain pads. The first pin carries the clock and the second carries the data. For each pin the register stores three things: whether the pad is pulled low or left released, the level it drives, and a pullup-disable flag. It also returns the level on each pad after a two-flop synchronizer.

Software never drives a high level. To get a high, it releases the pin, and the external pullup pulls the line up. To get a low, it turns the driver on with a value of zero. Each pin has a mask bit for its direction field and another for its value field. A write changes only the fields whose mask bit is set, so one pin can be moved without disturbing the other. A write with every mask clear leaves both pins as they are and changes only the pullup-disable flags. Sampling a pin therefore takes two writes and a read: release the pin, write the pullup-disable flags alone, then read the input bit.

Top module: `gpio_pair_ctl`

## Requirements
- R1: A write changes a pin's direction bit only when that pin's direction-mask bit is 1 in the same write. The clock pin uses mask bit 0 and direction bit 1. The data pin uses mask bit 8 and direction bit 9. Direction 1 means driven and direction 0 means released.
- R2: A write with the direction mask set and direction 0 turns the pin's `pad_oe` off on the next clock edge, so the pad is released.
- R3: A single write that sets the direction mask, direction 1, the value mask and value 0 makes the pin show `pad_oe`=1 and `pad_out`=0 on the next edge.
- R4: A write changes a pin's stored value only when that pin's value-mask bit is set. The clock pin uses value mask bit 2 and value bit 3. The data pin uses bits 10 and 11. `pad_out` always shows the stored value.
- R5: The pullup-disable bits are taken from every write and read back at the same positions: bit 5 for the clock pin and bit 13 for the data pin.
- R6: When `rd_en` is high at a clock edge, `rd_data` captures the register at that edge and keeps it until the next read. It returns direction at bits 1 and 9, value at bits 3 and 11, input at bits 4 and 12, and pullup-disable at bits 5 and 13. Every other bit reads 0. A write in the same cycle as a read does not appear in that read.
- R7: The input bit returned by a read taken at edge E equals the pad level sampled at edge E-2, because each pad passes through a two-flop synchronizer.
- R8: After reset both pins are released, both stored values and both pullup-disable bits are 0, and `rd_data` is 0.
- R9: A write whose masks select only one pin leaves the other pin's direction and value unchanged.
- R10: The sampling sequence works as intended. A write that releases the pin, then a write that sets only the pullup-disable bits, then a read returns the pad level while the pin stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data with mask, direction, value and pullup-disable fields |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Captured read data |
| pad_in | input | 2 | Pad levels (bit 0 clock, bit 1 data) |
| pad_oe | output | 2 | Drive enable for each pad |
| pad_out | output | 2 | Drive value for each pad |

## Verification
The hardest case to reach is a pad whose level differs from the value the register drives. This happens when another device holds the line low while the pin is released, and it matters because the synchronizer delay only shows when the pad moves while reads are taken on every cycle. The bench models open-drain pads in which an external pulldown can be forced on either line. It toggles that pulldown between back-to-back reads and checks each read against a two-deep history of sampled pad levels. It also issues reads in the same cycle as writes, and writes that touch only one pin or only the pullup-disable flags.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int REG_W      = 32;
  localparam int LANE_W     = 8;
  localparam int OFS_DMASK  = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_VMASK  = 2;
  localparam int OFS_VAL    = 3;
  localparam int OFS_IN     = 4;
  localparam int OFS_PUD    = 5;

  typedef struct packed {
    logic dmask;
    logic dir;
    logic vmask;
    logic val;
    logic pud;
  } lane_wr_t;

  // Extract one pin's write fields from the register word.
  function automatic lane_wr_t pick_lane(input logic [REG_W-1:0] w, input int lane);
    lane_wr_t f;
    int base;
    base    = lane * LANE_W;
    f.dmask = w[base + OFS_DMASK];
    f.dir   = w[base + OFS_DIR];
    f.vmask = w[base + OFS_VMASK];
    f.val   = w[base + OFS_VAL];
    f.pud   = w[base + OFS_PUD];
    return f;
  endfunction

  // Masked update: keep the current bit unless the mask is set.
  function automatic logic masked_next(input logic cur, input logic en, input logic nv);
    return en ? nv : cur;
  endfunction

  // Readback layout of one pin; mask positions always read 0.
  function automatic logic [LANE_W-1:0] pack_lane(input logic dir, input logic val,
                                                  input logic pin, input logic pud);
    logic [LANE_W-1:0] r;
    r = '0;
    r[OFS_DIR] = dir;
    r[OFS_VAL] = val;
    r[OFS_IN]  = pin;
    r[OFS_PUD] = pud;
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_lane.sv
module gpio_pin_lane
  import gpio_pair_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  lane_wr_t          fields,
  input  logic              pad_in,
  output logic              pad_oe,
  output logic              pad_out,
  output logic [LANE_W-1:0] lane_rd
);
  logic dir_q, val_q, pud_q, pin_sync;
  logic dir_upd, val_upd;

  assign dir_upd = wr_en & fields.dmask;
  assign val_upd = wr_en & fields.vmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b0;
      pud_q <= 1'b0;
    end else begin
      dir_q <= masked_next(dir_q, dir_upd, fields.dir);
      val_q <= masked_next(val_q, val_upd, fields.val);
      if (wr_en) pud_q <= fields.pud;
    end
  end

  gpio_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pin_sync)
  );

  assign pad_oe  = dir_q;
  assign pad_out = val_q;
  assign lane_rd = pack_lane(dir_q, val_q, pin_sync, pud_q);

  assert_dir_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fields.dmask) |=> $stable(pad_oe));
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fields.dmask && !fields.dir) |=> !pad_oe);
  assert_drive_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fields.dmask && fields.dir && fields.vmask && !fields.val) |=> (pad_oe && !pad_out));
  assert_val_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && fields.vmask)) |=> $stable(pad_out));
  assert_pud_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lane_rd[OFS_PUD] == $past(fields.pud)));
endmodule

// File: rtl/gpio_pair_ctl.sv
module gpio_pair_ctl
  import gpio_pair_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic                rd_en,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int USED_W = NUM_PINS * LANE_W;

  logic [REG_W-1:0] rd_next;

  generate
    if (USED_W < REG_W) begin : g_pad
      assign rd_next[REG_W-1:USED_W] = '0;
    end
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
      gpio_pin_lane #(.STAGES(STAGES)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .fields (pick_lane(wr_data, i)),
        .pad_in (pad_in[i]),
        .pad_oe (pad_oe[i]),
        .pad_out(pad_out[i]),
        .lane_rd(rd_next[i*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  assert_mask_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[OFS_DMASK] == 1'b0 && rd_data[OFS_VMASK] == 1'b0));
endmodule

// File: tb/gpio_pair_ctl_bench.sv
module gpio_pair_ctl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [31:0] rd_data;
  logic [1:0]  pad_in = 2'b11;
  logic [1:0]  pad_oe, pad_out;
  logic [1:0]  ext_low = 2'b00;

  int vectors = 0, miscompares = 0;
  string phase = "R8";
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pair_ctl u_gpio_pair_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // Open-drain pads: low if driven low or pulled down externally.
  always @(negedge clk)
    for (int i = 0; i < 2; i++)
      pad_in[i] <= ~ext_low[i] & ~(pad_oe[i] & ~pad_out[i]);

  // Reference model
  bit m_dir[2], m_val[2], m_pud[2];
  bit [31:0] m_rd;
  bit [1:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_dir[i] = 0; m_val[i] = 0; m_pud[i] = 0; end
      m_rd = 0;
      hist = '{2'b00, 2'b00};
    end else begin
      if (rd_en) begin
        m_rd = 0;
        for (int i = 0; i < 2; i++) begin
          m_rd[8*i+1] = m_dir[i];
          m_rd[8*i+3] = m_val[i];
          m_rd[8*i+4] = hist[0][i];
          m_rd[8*i+5] = m_pud[i];
        end
      end
      if (wr_en)
        for (int i = 0; i < 2; i++) begin
          if (wr_data[8*i+0]) m_dir[i] = wr_data[8*i+1];
          if (wr_data[8*i+2]) m_val[i] = wr_data[8*i+3];
          m_pud[i] = wr_data[8*i+5];
        end
      hist.push_back(pad_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit [1:0] eoe, eout;
      for (int i = 0; i < 2; i++) begin eoe[i] = m_dir[i]; eout[i] = m_val[i]; end
      vectors++;
      if (pad_oe !== eoe || pad_out !== eout || rd_data !== m_rd) begin
        miscompares++;
        $display("FAIL %s: oe=%b out=%b rd=%h expected oe=%b out=%b rd=%h",
                 phase, pad_oe, pad_out, rd_data, eoe, eout, m_rd);
      end
    end
  end

  function automatic logic [31:0] pin_bits(int p, bit dm, bit d, bit vm, bit v);
    logic [31:0] w = '0;
    w[8*p+0] = dm; w[8*p+1] = d; w[8*p+2] = vm; w[8*p+3] = v;
    return w;
  endfunction

  task automatic cyc(bit we, logic [31:0] d, bit re);
    wr_en = we; wr_data = d; rd_en = re;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R8"; cyc(0, 0, 1); cyc(0, 0, 0);
    phase = "R3"; cyc(1, pin_bits(0, 1, 1, 1, 0), 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1);
    phase = "R9"; cyc(1, pin_bits(1, 1, 1, 1, 0), 0); cyc(1, pin_bits(0, 1, 0, 0, 0), 1); cyc(0, 0, 1);
    phase = "R2"; cyc(1, pin_bits(1, 1, 0, 0, 0), 0); cyc(0, 0, 1);
    phase = "R1"; cyc(1, pin_bits(0, 0, 1, 0, 0), 1); cyc(1, pin_bits(1, 0, 1, 1, 1), 1); cyc(0, 0, 1);
    phase = "R4"; cyc(1, pin_bits(0, 0, 0, 1, 1), 1); cyc(1, pin_bits(0, 1, 1, 0, 0), 1);
    cyc(1, pin_bits(0, 0, 0, 0, 0) | 32'h8, 1); cyc(1, pin_bits(0, 0, 0, 1, 0), 1);
    cyc(1, pin_bits(0, 1, 0, 0, 0), 1);
    phase = "R5"; cyc(1, 32'h0000_2020, 1); cyc(0, 0, 1); cyc(1, 32'h0000_0020, 1); cyc(1, 0, 1); cyc(0, 0, 1);
    phase = "R6"; cyc(1, 32'hFFFF_FFFF, 1); cyc(0, 0, 1); cyc(1, pin_bits(0, 1, 0, 1, 0) | pin_bits(1, 1, 0, 1, 0), 0);
    cyc(0, 0, 0); cyc(0, 0, 1);
    phase = "R7";
    for (int k = 0; k < 12; k++) begin
      ext_low = 2'(k % 3);
      cyc(0, 0, 1);
    end
    ext_low = 0;
    phase = "R10";
    cyc(1, pin_bits(1, 1, 1, 1, 0), 0);
    cyc(1, pin_bits(1, 1, 0, 0, 0), 0);
    ext_low = 2'b10;
    cyc(1, 32'h0000_2020, 0); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    ext_low = 0; cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1);
    phase = "R8"; rst_n = 0; cyc(0, 0, 0); rst_n = 1; cyc(0, 0, 1); cyc(0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog in %s: actual hung expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule